// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word address for a synchronous burst RAM. An external address is loaded when either of two active-low start strobes is sampled low. One strobe comes from the processor side and one from the cache-controller side. After a load, the lowest `BURST_BITS` bits of the address step through a group of four beats. Each clock edge that samples the advance input low moves one beat. An edge that samples it high holds the address. The upper address bits keep the value that was loaded for the whole burst.

A static order input chooses how the low bits move. In linear order they count up and wrap within the group. In interleaved order each beat is the loaded offset XORed with the beat number. On every clock the block also decodes the cycle type from the strobes, the three chip enables and a write-request input: deselect, begin read, begin write, continue or suspend. It registers that type and passes it to the RAM core, together with a write flag and a chip-active flag. The storage array and the data path sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are `addr_out` = 0, `chip_act` = 0, `is_write` = 0 and `cyc_type` = 0 (deselect). The cycle-type codes are 0 deselect, 1 begin read, 2 begin write, 3 continue, 4 suspend.
- R2: A low `strb_proc_n` with `en1_n` low and the chip selected (`en1_n` low, `en2` high, `en3_n` low) loads `addr_in`. It always begins a read, whatever `strb_ctrl_n` and `wr_req` are: `cyc_type` = 1, `is_write` = 0, `chip_act` = 1 after that edge.
- R3: A low `strb_ctrl_n` with `strb_proc_n` high and the chip selected loads `addr_in`. It begins a write (`cyc_type` = 2, `is_write` = 1) when `wr_req` is high, and a read (`cyc_type` = 1, `is_write` = 0) when it is low.
- R4: An accepted strobe while the chip is not selected gives a deselect. So does a low `strb_ctrl_n` with `en1_n` high. A deselect gives `chip_act` = 0, `is_write` = 0 and `cyc_type` = 0, and leaves `addr_out` unchanged.
- R5: With `en1_n` high, `strb_proc_n` is ignored. With `strb_ctrl_n` high, the cycle is then a continue or a suspend: no load and no deselect.
- R6: With `order_il` = 0, beat k after a load with low offset s has low bits (s + k) mod 4. For example, s = 2 gives 2, 3, 0, 1.
- R7: With `order_il` = 1, beat k has low bits s XOR (k mod 4). For example, s = 1 gives 1, 0, 3, 2.
- R8: With both strobes inactive and `adv_n` high, the cycle is a suspend (`cyc_type` = 4). `addr_out`, `is_write` and `chip_act` keep their values.
- R9: Advances past the fourth beat keep wrapping within the same four-word group. The upper `ADDR_W-BURST_BITS` bits of `addr_out` never change without a load.
- R10: Continue cycles (`cyc_type` = 3) and suspend cycles ignore `en2`, `en3_n` and `en1_n`, and keep `chip_act` and `is_write`.
- R11: An accepted strobe in the middle of a burst aborts it. The next beat sequence starts again from the newly loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs except `order_il` are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| order_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| strb_proc_n | input | 1 | Processor-side start strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Advance to next beat when low, hold when high |
| en1_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| en2 | input | 1 | Depth-expansion enable, active high |
| en3_n | input | 1 | Depth-expansion enable, active low |
| wr_req | input | 1 | Write condition present (global or any byte write) |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Current word address to the RAM core |
| is_write | output | 1 | Current burst is a write |
| chip_act | output | 1 | Chip is selected for the current burst |
| cyc_type | output | 3 | Registered cycle type of the last clock |

## Verification
Two functions can land in the same cycle: a start strobe and a pending advance. In that case the strobe must win. The same goes for the two strobes sampled low together, where the processor strobe must force a read even though a write is requested on the controller side. The bench provokes both. It drives `adv_n` low on the same edge as a mid-burst strobe, and it drives both strobes low with `wr_req` high. It judges each case by checking that `addr_out` equals the new external address (not an advanced one), and that `is_write` and `cyc_type` show a read.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
// Package: shared cycle-type encoding for the burst sequencer.
// Assumes: codes are exported on cyc_type and decoded by the RAM core.
package burst_seq_pkg;
    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_RD_BEGIN = 3'd1,
        CYC_WR_BEGIN = 3'd2,
        CYC_CONT     = 3'd3,
        CYC_SUSP     = 3'd4
    } cyc_e;
endpackage

// File: rtl/burst_cycle_decode.sv
`timescale 1ns/1ps
// Module: burst_cycle_decode
// Combinational decode of one clock's controls into a cycle type.
// Assumes: the processor strobe has priority over the controller strobe.
// When en1_n is high, the processor strobe is ignored entirely.
module burst_cycle_decode
    import burst_seq_pkg::*;
(
    input  logic strb_proc_n,
    input  logic strb_ctrl_n,
    input  logic adv_n,
    input  logic en1_n,
    input  logic en2,
    input  logic en3_n,
    input  logic wr_req,
    output cyc_e cyc,
    output logic load
);
    logic sel;
    logic proc_take;
    logic ctrl_take;

    // Purpose: qualify the strobes and the full chip select.
    always_comb begin
        sel       = ~en1_n & en2 & ~en3_n;
        proc_take = ~strb_proc_n & ~en1_n;
        ctrl_take = ~strb_ctrl_n;
    end

    // Purpose: choose the cycle type by strobe priority.
    always_comb begin
        if (proc_take) begin
            cyc = sel ? CYC_RD_BEGIN : CYC_DESEL;
        end else if (ctrl_take) begin
            if (!sel)
                cyc = CYC_DESEL;
            else if (strb_proc_n && wr_req)
                cyc = CYC_WR_BEGIN;
            else
                cyc = CYC_RD_BEGIN;
        end else begin
            cyc = adv_n ? CYC_SUSP : CYC_CONT;
        end
        load = (cyc == CYC_RD_BEGIN) || (cyc == CYC_WR_BEGIN);
    end
endmodule

// File: rtl/burst_beat_ctr.sv
`timescale 1ns/1ps
// Module: burst_beat_ctr
// Holds the loaded low offset and a beat count, and forms the low address bits.
// Assumes: order_il is static; it is applied without a register.
// The count wraps within 2**BURST_BITS beats and never carries upward.
module burst_beat_ctr #(
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic                  order_il,
    input  logic [BURST_BITS-1:0] start_in,
    output logic [BURST_BITS-1:0] low_addr
);
    logic [BURST_BITS-1:0] start_q;
    logic [BURST_BITS-1:0] beat_q;

    // Purpose: capture the offset on a load, otherwise count beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            start_q <= start_in;
            beat_q  <= '0;
        end else if (step) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    // Purpose: map the beat number to an address by the selected order.
    always_comb begin
        if (order_il)
            low_addr = start_q ^ beat_q;
        else
            low_addr = start_q + beat_q;
    end
endmodule

// File: rtl/burst_addr_seq.sv
`timescale 1ns/1ps
// Module: burst_addr_seq (top)
// Burst word-address sequencer: loads an external address on a start strobe,
// steps the low bits by the chosen order, and registers cycle type, write flag
// and chip-active flag.
// Assumes: ADDR_W > BURST_BITS; order_il is tied off or changed only while idle.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_il,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              en1_n,
    input  logic              en2,
    input  logic              en3_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              is_write,
    output logic              chip_act,
    output logic [2:0]        cyc_type
);
    localparam int UP_W = ADDR_W - BURST_BITS;

    cyc_e                  cyc_d;
    cyc_e                  cyc_q;
    logic                  load;
    logic [UP_W-1:0]       upper_q;
    logic [BURST_BITS-1:0] low_addr;

    burst_cycle_decode u_dec (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .en1_n       (en1_n),
        .en2         (en2),
        .en3_n       (en3_n),
        .wr_req      (wr_req),
        .cyc         (cyc_d),
        .load        (load)
    );

    burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (cyc_d == CYC_CONT),
        .order_il (order_il),
        .start_in (addr_in[BURST_BITS-1:0]),
        .low_addr (low_addr)
    );

    // Purpose: update upper address, flags and cycle type from the decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper_q  <= '0;
            is_write <= 1'b0;
            chip_act <= 1'b0;
            cyc_q    <= CYC_DESEL;
        end else begin
            cyc_q <= cyc_d;
            case (cyc_d)
                CYC_DESEL: begin
                    chip_act <= 1'b0;
                    is_write <= 1'b0;
                end
                CYC_RD_BEGIN: begin
                    upper_q  <= addr_in[ADDR_W-1:BURST_BITS];
                    chip_act <= 1'b1;
                    is_write <= 1'b0;
                end
                CYC_WR_BEGIN: begin
                    upper_q  <= addr_in[ADDR_W-1:BURST_BITS];
                    chip_act <= 1'b1;
                    is_write <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    // Purpose: assemble the exported address and cycle code.
    always_comb begin
        addr_out = {upper_q, low_addr};
        cyc_type = cyc_q;
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
`timescale 1ns/1ps
// Module: burst_addr_seq_chk
// Port-level properties of the sequencer, bound into every instance.
// Assumes: order_il changes only while no burst is active.
module burst_addr_seq_chk #(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              order_il,
    input logic              strb_proc_n,
    input logic              strb_ctrl_n,
    input logic              adv_n,
    input logic              en1_n,
    input logic              en2,
    input logic              en3_n,
    input logic              wr_req,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              is_write,
    input logic              chip_act,
    input logic [2:0]        cyc_type
);
    logic sel;
    logic proc_ok;
    logic idle_in;

    // Purpose: helper terms built from the input pins only.
    always_comb begin
        sel     = ~en1_n & en2 & ~en3_n;
        proc_ok = ~strb_proc_n & ~en1_n;
        idle_in = strb_ctrl_n & ~proc_ok;
    end

    AST_PROC_LOADS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_ok && sel) |=> (addr_out == $past(addr_in)) && !is_write && chip_act); // R2

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctrl_n && strb_proc_n && sel && wr_req) |=> is_write && (cyc_type == 3'd2)); // R3

    AST_DESELECT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((proc_ok || !strb_ctrl_n) && !sel) |=> !chip_act && !is_write); // R4

    AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_in && adv_n) |=> ($stable(addr_out) || ($past(order_il) != order_il))); // R8

    AST_IDLE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        idle_in |=> $stable(chip_act) && $stable(is_write)); // R10

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        idle_in |=> $stable(addr_out[ADDR_W-1:BURST_BITS])); // R9
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module burst_addr_seq_bench;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          order_il = 1'b0;
    logic          strb_proc_n = 1'b1;
    logic          strb_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          en1_n = 1'b0;
    logic          en2 = 1'b1;
    logic          en3_n = 1'b0;
    logic          wr_req = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic          is_write;
    logic          chip_act;
    logic [2:0]    cyc_type;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) u_burst_addr_seq (
        .clk (clk), .rst_n (rst_n), .order_il (order_il),
        .strb_proc_n (strb_proc_n), .strb_ctrl_n (strb_ctrl_n), .adv_n (adv_n),
        .en1_n (en1_n), .en2 (en2), .en3_n (en3_n), .wr_req (wr_req),
        .addr_in (addr_in), .addr_out (addr_out), .is_write (is_write),
        .chip_act (chip_act), .cyc_type (cyc_type)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0; wr_req = 1'b0;
    endtask

    function automatic logic [1:0] ref_low(input logic [1:0] s, input int k, input logic m);
        logic [1:0] kk;
        kk = k[1:0];
        return m ? (s ^ kk) : (s + kk);
    endfunction

    task automatic load_ctrl(input logic [AW-1:0] a, input logic w);
        idle(); strb_ctrl_n = 1'b0; wr_req = w; addr_in = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; addr_in = 17'h1FFFF; strb_ctrl_n = 1'b0; wr_req = 1'b1;
        tick(); tick();
        chk("R1 addr", 32'(addr_out), 32'h0);
        chk("R1 chip_act", 32'(chip_act), 32'h0);
        chk("R1 is_write", 32'(is_write), 32'h0);
        chk("R1 cyc_type", 32'(cyc_type), 32'h0);
        idle(); rst_n = 1'b1;
        tick();
    endtask

    task automatic t_proc_read();
        idle(); strb_proc_n = 1'b0; strb_ctrl_n = 1'b0; wr_req = 1'b1;
        adv_n = 1'b0; addr_in = 17'h1A5F6;
        tick(); idle();
        chk("R2 addr", 32'(addr_out), 32'h1A5F6);
        chk("R2 is_write", 32'(is_write), 32'h0);
        chk("R2 chip_act", 32'(chip_act), 32'h1);
        chk("R2 cyc_type", 32'(cyc_type), 32'h1);
    endtask

    task automatic t_ctrl_rw();
        load_ctrl(17'h0C3A1, 1'b1);
        chk("R3 write addr", 32'(addr_out), 32'h0C3A1);
        chk("R3 is_write", 32'(is_write), 32'h1);
        chk("R3 cyc write", 32'(cyc_type), 32'h2);
        load_ctrl(17'h13002, 1'b0);
        chk("R3 read addr", 32'(addr_out), 32'h13002);
        chk("R3 is_write read", 32'(is_write), 32'h0);
        chk("R3 cyc read", 32'(cyc_type), 32'h1);
    endtask

    task automatic t_deselect();
        load_ctrl(17'h0AAA8, 1'b1);
        idle(); en2 = 1'b0; strb_ctrl_n = 1'b0; addr_in = 17'h15555;
        tick();
        chk("R4 en2 chip_act", 32'(chip_act), 32'h0);
        chk("R4 en2 is_write", 32'(is_write), 32'h0);
        chk("R4 en2 cyc", 32'(cyc_type), 32'h0);
        chk("R4 addr held", 32'(addr_out), 32'h0AAA8);
        load_ctrl(17'h0AAA8, 1'b0);
        idle(); en3_n = 1'b1; strb_proc_n = 1'b0; addr_in = 17'h15555;
        tick();
        chk("R4 en3 proc chip_act", 32'(chip_act), 32'h0);
        load_ctrl(17'h0AAA8, 1'b0);
        idle(); en1_n = 1'b1; strb_ctrl_n = 1'b0; addr_in = 17'h15555;
        tick();
        chk("R4 en1 ctrl cyc", 32'(cyc_type), 32'h0);
        chk("R4 en1 ctrl chip_act", 32'(chip_act), 32'h0);
        idle();
    endtask

    task automatic t_proc_ignored();
        order_il = 1'b0;
        load_ctrl(17'h04441, 1'b1);
        idle(); en1_n = 1'b1; strb_proc_n = 1'b0; addr_in = 17'h1FFFC;
        tick();
        chk("R5 addr held", 32'(addr_out), 32'h04441);
        chk("R5 chip_act", 32'(chip_act), 32'h1);
        chk("R5 cyc suspend", 32'(cyc_type), 32'h4);
        adv_n = 1'b0;
        tick();
        chk("R5 advances", 32'(addr_out), 32'h04442);
        chk("R5 cyc cont", 32'(cyc_type), 32'h3);
        idle(); en2 = 1'b0; en3_n = 1'b1; adv_n = 1'b0;
        tick();
        chk("R10 cont chip_act", 32'(chip_act), 32'h1);
        chk("R10 cont is_write", 32'(is_write), 32'h1);
        chk("R10 cont addr", 32'(addr_out), 32'h04443);
        adv_n = 1'b1;
        tick();
        chk("R10 susp chip_act", 32'(chip_act), 32'h1);
        idle();
    endtask

    task automatic t_orders();
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                logic [AW-3:0] up;
                up = 15'(15'h2B1 + 15'(s * 97 + m * 1000));
                idle(); order_il = m[0];
                load_ctrl({up, s[1:0]}, 1'b0);
                chk(m ? "R7 start" : "R6 start", 32'(addr_out), 32'({up, s[1:0]}));
                for (int k = 1; k <= 6; k++) begin
                    idle(); adv_n = 1'b0;
                    tick();
                    chk(m ? "R7 beat" : "R6 beat", 32'(addr_out[1:0]),
                        32'(ref_low(s[1:0], k, m[0])));
                    chk("R9 upper", 32'(addr_out[AW-1:2]), 32'(up));
                end
                idle();
            end
        end
        order_il = 1'b0;
    endtask

    task automatic t_suspend();
        order_il = 1'b0;
        load_ctrl(17'h10F0D, 1'b1);
        adv_n = 1'b0; tick();
        idle();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8 addr", 32'(addr_out), 32'h10F0E);
            chk("R8 is_write", 32'(is_write), 32'h1);
            chk("R8 cyc", 32'(cyc_type), 32'h4);
        end
    endtask

    task automatic t_abort();
        order_il = 1'b0;
        load_ctrl(17'h01232, 1'b0);
        adv_n = 1'b0; tick(); tick();
        chk("R11 mid burst", 32'(addr_out), 32'h01230);
        idle(); strb_proc_n = 1'b0; adv_n = 1'b0; addr_in = 17'h0BEE1;
        tick();
        chk("R11 reload", 32'(addr_out), 32'h0BEE1);
        idle(); adv_n = 1'b0;
        tick();
        chk("R11 restart", 32'(addr_out), 32'h0BEE2);
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_proc_read();
        t_ctrl_rw();
        t_deselect();
        t_proc_ignored();
        t_orders();
        t_suspend();
        t_abort();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule